// File: doc/BRIEF.md
# Multiplexed-Address DRAM Strobe Controller

This block sits between a simple host request port and a DRAM-style device whose address pins carry the row half and the column half of a word address at different times. The host presents a flat word address, a write flag and write data together with a request strobe. The block latches them and puts the upper half of the address on the shared bus. It pulses the active-low row strobe, switches the bus to the lower half and pulses the active-low column strobe, with the write-enable line asserted during that pulse on a write. It then waits out a precharge interval and returns a one-cycle done pulse.

Every phase length is a parameter counted in clock cycles: address setup before each strobe, row settle time, column pulse width and precharge. The address on the bus is set one setup interval before the strobe that uses it falls, and it does not move while that strobe is low. On a read, the data pins are sampled on the final cycle of the column pulse. The value is presented to the host with the done pulse and held until the next read completes.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: After a synchronous reset, the row strobe, column strobe and write-enable are all high, and done is low.
- R2: The row half is host address bits [15:8]. It is on the memory address bus for every cycle the row strobe is low. The column half is bits [7:0], on the bus for every cycle the column strobe is low. The row pulse of an operation always comes before its column pulse.
- R3: The memory address bus holds the same value on the cycle before each strobe falls and on every cycle that strobe stays low.
- R4: The row strobe stays low for exactly T_ROW cycles and returns high before the column strobe falls. The two strobes are never low together.
- R5: The column strobe stays low for exactly T_COL cycles per operation.
- R6: After the column strobe rises, all strobes stay high for T_PRE cycles, and done is then high. Counted from the accepting clock edge, done is seen on cycle 2*T_SETUP + T_ROW + T_COL + T_PRE + 1.
- R7: On a write, write-enable is low on exactly the cycles the column strobe is low, and the memory write-data pins carry the host's write data. On a read, write-enable stays high.
- R8: On a read, the data returned is the memory read-data value on the last column-strobe cycle. It is valid while done is high and is held unchanged through later writes until the next read completes.
- R9: A request is accepted only when the block is idle. A request raised while an operation is running, and withdrawn before the block returns to idle, starts no operation and writes nothing.
- R10: Done is high for exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request; sampled only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*HALF_W | Flat word address (row half high, column half low) |
| req_wdata | input | DATA_W | Write data |
| req_done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Read result, held until the next read completes |
| mem_addr | output | HALF_W | Shared row/column address bus |
| mem_ras_n | output | 1 | Active-low row strobe |
| mem_cas_n | output | 1 | Active-low column strobe |
| mem_we_n | output | 1 | Active-low write enable |
| mem_wdata | output | DATA_W | Data driven to the memory |
| mem_rdata | input | DATA_W | Data returned from the memory |

## Verification
The bench's pin-level memory model drives valid read data only on the final column-strobe cycle and junk on the others. A controller that samples one cycle early therefore returns the junk word instead of the stored one. A request held high with a different address while an operation runs tests the idle-only acceptance rule. A design that took it would run a second pulse train, or write to that address, and a later read-back would show it. Strobe pulse widths are measured at the pins and checked against the parameters, which catches an off-by-one in the shared down-counter. The address seen under each strobe is compared against the host address halves, which catches a swapped row/column mux or a bus that changes while a strobe is low.

// File: rtl/dsc_pkg.sv
// Shared types for the DRAM strobe controller.
package dsc_pkg;
    // Sequencer phases, in the order a single operation walks through them.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_SET,
        ST_ROW_ACT,
        ST_COL_SET,
        ST_COL_ACT,
        ST_PRECH,
        ST_DONE
    } phase_e;
endpackage

// File: rtl/dsc_timer.sv
// Phase down-counter. A load writes len-1; the counter then counts to zero
// and holds there. 'expired' is high on the last cycle of a phase.
// Assumes every loaded length is at least 1.
module dsc_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Count down the remaining cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_len - CNT_W'(1);
        else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expired = (cnt_q == '0);

    // R5: without a load the count moves down by exactly one until zero.
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/dsc_addr_latch.sv
// Captures the host request when it is accepted. Drives the shared address
// bus with the row half or the column half, as the sequencer selects.
// Assumes 'capture' is raised only while idle.
module dsc_addr_latch #(
    parameter int HALF_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  logic [2*HALF_W-1:0]   host_addr,
    input  logic                  host_write,
    input  logic [DATA_W-1:0]     host_wdata,
    input  logic                  col_sel,
    output logic [HALF_W-1:0]     bus_addr,
    output logic                  write_q,
    output logic [DATA_W-1:0]     wdata_q
);
    logic [HALF_W-1:0] row_q;
    logic [HALF_W-1:0] col_q;

    // Hold the row, column, direction and data of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            col_q   <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
        end else if (capture) begin
            row_q   <= host_addr[2*HALF_W-1:HALF_W];
            col_q   <= host_addr[HALF_W-1:0];
            write_q <= host_write;
            wdata_q <= host_wdata;
        end
    end

    // Select which latched half appears on the shared pins.
    always_comb begin
        bus_addr = col_sel ? col_q : row_q;
    end

    // R9: the latched request cannot change unless a capture occurs.
    a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(row_q) && $stable(col_q) && $stable(write_q)));
endmodule

// File: rtl/dsc_sequencer.sv
// Phase sequencer: idle -> row setup -> row strobe -> column setup ->
// column strobe -> precharge -> done -> idle. Every timed phase gets its
// length loaded into the shared timer on entry. Pin controls decode from
// the registered phase. Assumes every timing parameter is at least 1.
module dsc_sequencer
    import dsc_pkg::*;
#(
    parameter int T_SETUP = 1,
    parameter int T_ROW   = 3,
    parameter int T_COL   = 2,
    parameter int T_PRE   = 2,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             write_q,
    input  logic             expired,
    output logic             load,
    output logic [CNT_W-1:0] load_len,
    output logic             capture,
    output logic             col_sel,
    output logic             sample_rd,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             done
);
    phase_e state_q, state_d;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next phase: idle waits for a request, timed phases wait for expiry.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_ROW_SET;
            ST_ROW_SET: if (expired)   state_d = ST_ROW_ACT;
            ST_ROW_ACT: if (expired)   state_d = ST_COL_SET;
            ST_COL_SET: if (expired)   state_d = ST_COL_ACT;
            ST_COL_ACT: if (expired)   state_d = ST_PRECH;
            ST_PRECH:   if (expired)   state_d = ST_DONE;
            ST_DONE:                   state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // Timer load on every entry to a timed phase, with that phase's length.
    always_comb begin
        load     = 1'b0;
        load_len = CNT_W'(1);
        if (state_d != state_q) begin
            unique case (state_d)
                ST_ROW_SET, ST_COL_SET: begin load = 1'b1; load_len = CNT_W'(T_SETUP); end
                ST_ROW_ACT:             begin load = 1'b1; load_len = CNT_W'(T_ROW);   end
                ST_COL_ACT:             begin load = 1'b1; load_len = CNT_W'(T_COL);   end
                ST_PRECH:               begin load = 1'b1; load_len = CNT_W'(T_PRE);   end
                default:                begin load = 1'b0; load_len = CNT_W'(1);       end
            endcase
        end
    end

    // Pin and datapath controls decoded from the registered phase.
    always_comb begin
        capture   = (state_q == ST_IDLE) && req_valid;
        col_sel   = (state_q == ST_COL_SET) || (state_q == ST_COL_ACT);
        ras_n     = (state_q != ST_ROW_ACT);
        cas_n     = (state_q != ST_COL_ACT);
        we_n      = !((state_q == ST_COL_ACT) && write_q);
        sample_rd = (state_q == ST_COL_ACT) && expired && !write_q;
        done      = (state_q == ST_DONE);
    end

    // R4: row and column strobes are never active together.
    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ras_n && !cas_n));
    // R9: an operation starts only from idle.
    a_r9_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ROW_SET && $past(state_q) != ST_ROW_SET) |-> ($past(state_q) == ST_IDLE));
    // R6: done follows the precharge phase.
    a_r6_done_after_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state_q) == ST_PRECH));
    // R10: done lasts one cycle.
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/dram_strobe_ctrl.sv
// Top level of the multiplexed-address DRAM strobe controller. Ties the
// request latch, phase sequencer and phase timer together and registers the
// read result. Assumes the host holds the request fields stable in the
// cycle req_valid is seen while idle.
module dram_strobe_ctrl #(
    parameter int HALF_W  = 8,
    parameter int DATA_W  = 16,
    parameter int T_SETUP = 1,
    parameter int T_ROW   = 3,
    parameter int T_COL   = 2,
    parameter int T_PRE   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [2*HALF_W-1:0] req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                req_done,
    output logic [DATA_W-1:0]   rd_data,
    output logic [HALF_W-1:0]   mem_addr,
    output logic                mem_ras_n,
    output logic                mem_cas_n,
    output logic                mem_we_n,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata
);
    localparam int MAX_A   = (T_ROW > T_COL) ? T_ROW : T_COL;
    localparam int MAX_B   = (T_PRE > T_SETUP) ? T_PRE : T_SETUP;
    localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic             load;
    logic [CNT_W-1:0] load_len;
    logic             expired;
    logic             capture;
    logic             col_sel;
    logic             sample_rd;
    logic             write_q;
    logic [DATA_W-1:0] rd_q;

    dsc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_len (load_len),
        .expired  (expired)
    );

    dsc_addr_latch #(.HALF_W(HALF_W), .DATA_W(DATA_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .host_addr  (req_addr),
        .host_write (req_write),
        .host_wdata (req_wdata),
        .col_sel    (col_sel),
        .bus_addr   (mem_addr),
        .write_q    (write_q),
        .wdata_q    (mem_wdata)
    );

    dsc_sequencer #(
        .T_SETUP (T_SETUP),
        .T_ROW   (T_ROW),
        .T_COL   (T_COL),
        .T_PRE   (T_PRE),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .write_q   (write_q),
        .expired   (expired),
        .load      (load),
        .load_len  (load_len),
        .capture   (capture),
        .col_sel   (col_sel),
        .sample_rd (sample_rd),
        .ras_n     (mem_ras_n),
        .cas_n     (mem_cas_n),
        .we_n      (mem_we_n),
        .done      (req_done)
    );

    // Capture memory read data on the final column-strobe cycle of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_q <= '0;
        else if (sample_rd) rd_q <= mem_rdata;
    end

    assign rd_data = rd_q;

    // R1: first cycle out of reset has all strobes idle and no done.
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mem_ras_n && mem_cas_n && mem_we_n && !req_done));
    // R7: write enable only inside the column pulse.
    a_r7_we_inside_cas: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cas_n);
    // R3: address steady from the setup cycle through the row pulse.
    a_r3_addr_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ras_n |-> $stable(mem_addr));
    // R3: address steady from the setup cycle through the column pulse.
    a_r3_addr_under_cas: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cas_n |-> $stable(mem_addr));
endmodule

// File: tb/dram_strobe_ctrl_tb.sv
// Self-checking bench: host driver, pin-level memory model, strobe monitor.
module dram_strobe_ctrl_tb;
    localparam int HALF_W  = 8;
    localparam int DATA_W  = 16;
    localparam int T_SETUP = 1;
    localparam int T_ROW   = 3;
    localparam int T_COL   = 2;
    localparam int T_PRE   = 2;
    localparam int LAT     = 2*T_SETUP + T_ROW + T_COL + T_PRE + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic req_done;
    logic [15:0] rd_data;
    logic [7:0]  mem_addr;
    logic mem_ras_n, mem_cas_n, mem_we_n;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'hBAD0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dram_strobe_ctrl #(
        .HALF_W(HALF_W), .DATA_W(DATA_W), .T_SETUP(T_SETUP),
        .T_ROW(T_ROW), .T_COL(T_COL), .T_PRE(T_PRE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_ras_n(mem_ras_n),
        .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Initial memory content, shared by the golden array and the pin model.
    function automatic logic [15:0] init_word(input logic [15:0] a);
        return (a * 16'd37) ^ 16'h6B1D;
    endfunction

    logic [15:0] gold [logic [15:0]];
    logic [15:0] mdl  [logic [15:0]];

    function automatic logic [15:0] gold_rd(input logic [15:0] a);
        return gold.exists(a) ? gold[a] : init_word(a);
    endfunction

    // Expected fields of the operation in flight.
    logic [7:0]  exp_row = '0, exp_col = '0;
    logic        exp_write = 1'b0;
    logic [15:0] exp_wdata = '0;

    // Pin-level monitor and memory model, sampling at the falling edge.
    logic prev_ras = 1'b1, prev_cas = 1'b1, prev_done = 1'b0;
    logic [7:0] prev_addr = '0;
    logic [7:0] row_lat = '0;
    int ras_run = 0, cas_run = 0;
    bit seen_row = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ras_n) begin
                ras_run++;
                seen_row = 1'b1;
                row_lat  = mem_addr;
                check(mem_addr == exp_row, "R2 row half", mem_addr, exp_row);
                check(mem_addr == prev_addr, "R3 addr steady under row strobe", mem_addr, prev_addr);
                check(mem_cas_n, "R4 strobes overlap", mem_cas_n, 1);
            end else if (!prev_ras) begin
                check(ras_run == T_ROW, "R4 row pulse width", ras_run, T_ROW);
                ras_run = 0;
            end
            if (!mem_cas_n) begin
                cas_run++;
                if (cas_run == 1) check(seen_row && mem_ras_n, "R2 row before column", seen_row, 1);
                check(mem_addr == exp_col, "R2 column half", mem_addr, exp_col);
                check(mem_addr == prev_addr, "R3 addr steady under column strobe", mem_addr, prev_addr);
                check(mem_we_n == !exp_write, "R7 write enable level", mem_we_n, !exp_write);
                if (!mem_we_n) begin
                    check(mem_wdata == exp_wdata, "R7 write data", mem_wdata, exp_wdata);
                    mdl[{row_lat, mem_addr}] = mem_wdata;
                end
                if (cas_run == T_COL) begin
                    logic [15:0] k;
                    k = {row_lat, mem_addr};
                    mem_rdata <= mdl.exists(k) ? mdl[k] : init_word(k);
                end else begin
                    mem_rdata <= 16'hBAD0 ^ 16'(cas_run);
                end
            end else begin
                mem_rdata <= 16'hBAD0;
                if (!prev_cas) begin
                    check(cas_run == T_COL, "R5 column pulse width", cas_run, T_COL);
                    cas_run = 0;
                end
                check(mem_we_n, "R7 write enable outside column pulse", mem_we_n, 1);
            end
            if (req_done) begin
                check(!prev_done, "R10 done single cycle", prev_done, 0);
                seen_row = 1'b0;
            end
        end
        prev_ras  = mem_ras_n;
        prev_cas  = mem_cas_n;
        prev_done = req_done;
        prev_addr = mem_addr;
    end

    logic [15:0] last_rd = '0;

    // Run one host operation; optionally poke a request while busy.
    task automatic run_op(input logic wr, input logic [15:0] a, input logic [15:0] d, input bit poke);
        int n;
        @(negedge clk);
        exp_row = a[15:8]; exp_col = a[7:0]; exp_write = wr; exp_wdata = d;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                if (poke) begin
                    req_write = 1'b1; req_addr = a ^ 16'h5A5A; req_wdata = ~d;
                end else begin
                    req_valid = 1'b0;
                end
            end
        end while (!req_done && n < 4*LAT);
        req_valid = 1'b0;
        check(n == LAT, "R6 done latency", n, LAT);
        if (wr) begin
            gold[a] = d;
            check(rd_data == last_rd, "R8 read data held over write", rd_data, last_rd);
        end else begin
            check(rd_data == gold_rd(a), "R8 read data", rd_data, gold_rd(a));
            last_rd = rd_data;
        end
        if (poke) begin
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                check(mem_ras_n && !req_done, "R9 busy request ignored", mem_ras_n, 1);
            end
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] a;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mem_ras_n && mem_cas_n && mem_we_n && !req_done, "R1 reset state",
              {mem_ras_n, mem_cas_n, mem_we_n, req_done}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_ras_n && mem_cas_n && mem_we_n && !req_done, "R1 idle after reset",
              {mem_ras_n, mem_cas_n, mem_we_n, req_done}, 4'b1110);

        // Directed corners.
        run_op(1'b0, 16'h0000, 16'h0, 1'b0);
        run_op(1'b1, 16'hFFFF, 16'hC0DE, 1'b0);
        run_op(1'b0, 16'hFFFF, 16'h0, 1'b0);
        run_op(1'b1, 16'h12EF, 16'h1234, 1'b0);
        run_op(1'b0, 16'hEF12, 16'h0, 1'b0);
        run_op(1'b0, 16'h12EF, 16'h0, 1'b0);
        // R9: busy poke during a read; the poked address must keep its content.
        run_op(1'b0, 16'h0F0F, 16'h7777, 1'b1);
        run_op(1'b0, 16'h0F0F ^ 16'h5A5A, 16'h0, 1'b0);
        run_op(1'b1, 16'h3333, 16'h9999, 1'b1);
        run_op(1'b0, 16'h3333 ^ 16'h5A5A, 16'h0, 1'b0);

        // Random mix over a small address pool so locations are revisited.
        for (int i = 0; i < 120; i++) begin
            a = 16'($urandom) & 16'hC3C3;
            run_op(1'($urandom), a, 16'($urandom), 1'($urandom_range(0, 7) == 0));
        end
        for (int i = 0; i < 6; i++) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule